// File: doc/BRIEF.md
# Converter Power Mode Controller

This block is the digital sequencer that sets the power state of a two-channel simultaneous-sampling successive-approximation converter. A frame opens when the active-low frame select drops. The block counts the falling edges of the serial clock inside that frame. When the select line returns high, the count decides what happens next. An early release is treated as a glitch and changes nothing. A release in the middle window powers down most of the analog core. A release in the late window keeps the core powered but drops the conversion. A full frame completes normally.

Opening a frame while powered down starts a wake-up. That first frame is a dummy. If it is held long enough, the device returns to normal operation. If it is released in the middle window, the device sinks into the deepest sleep instead. A wake-up counter, set separately for each sleep depth, decides when later conversions may be flagged as valid. The block drives enables for the analog core and the reference buffers. It also drives a one-cycle abort strobe, a track control for the sample stage, a data-valid qualifier and a ready flag.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: After reset the mode is the `RESET_MODE` parameter (default normal, code 0), with ready high, abort strobe low, data-valid low, both enables high and track high. Mode codes: 0 normal, 1 light sleep (reference kept), 2 deep sleep, 3 waking.
- R2: In normal mode, releasing select after fewer than `EDGE_KEEP` (2) serial-clock falls leaves the mode normal and gives no abort.
- R3: In normal mode, a release after at least 2 and fewer than `EDGE_STAY` (10) falls moves to mode 1. The abort strobe goes high for exactly the one clock cycle after the release is seen.
- R4: In normal mode, a release after at least 10 and fewer than `FRAME_EDGES` (16) falls keeps the mode normal and pulses the abort strobe for one cycle.
- R5: In normal mode with ready high, a frame of at least 16 falls raises data-valid once the 16th fall is counted. Data-valid stays high until the release, and no abort follows.
- R6: A select fall in mode 1 or 2 enters mode 3 on the next cycle. Track is low until the first serial-clock fall of that frame and high from then on.
- R7: Releasing a waking frame after fewer than 2 falls returns to the sleep mode it started from.
- R8: Releasing a waking frame after 2 to 9 falls goes to mode 2, whichever sleep it came from.
- R9: Releasing a waking frame after 10 or more falls goes to normal mode. Ready is high only when in normal mode and at least `PUP_PART_CYC` (light) or `PUP_FULL_CYC` (deep) clock cycles have passed since the cycle that saw the select fall.
- R10: Enables per mode: normal and waking have core=1 and reference=1, mode 1 has core=0 and reference=1, mode 2 has both 0.
- R11: A frame opened in normal mode while ready is low, and any waking frame, never raise data-valid.
- R12: In normal mode, track is low from the cycle after a select fall until the 16th fall is counted or select is released, and high otherwise. Track is low in modes 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial clock and select are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select, synchronous to clk |
| sclk | input | 1 | Serial clock, synchronous to clk |
| mode | output | 2 | Current mode code (see R1) |
| core_en | output | 1 | Power enable for converter core and sample stage |
| refbuf_en | output | 1 | Power enable for reference and its buffers |
| abort_stb | output | 1 | One-cycle strobe: drop conversion, release data lines |
| track_en | output | 1 | Sample stage tracking (1) or holding/off (0) |
| ready | output | 1 | Wake-up time has elapsed in normal mode |
| data_valid | output | 1 | Current frame carries a valid result |

## Verification
The hardest situations to reach are the ones that depend on history. One is a second middle-window release while waking from light sleep, which must fall into deep sleep rather than light sleep. Another is a full-length frame opened after a deep wake but before its counter expires, which must stay unqualified. Directed frames walk normal, light sleep, deep sleep, waking and back to normal, and then probe the ready flag on the exact cycle its count ends. A seeded random run of frames with 0 to 20 falls and random idle gaps, some long enough to finish a wake-up, then covers the other orderings of windows and modes.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL  = 2'd0,
    PM_PARTIAL = 2'd1,
    PM_FULL    = 2'd2,
    PM_WAKING  = 2'd3
  } pm_mode_e;

  typedef enum logic [1:0] {
    WIN_EARLY = 2'd0,
    WIN_MID   = 2'd1,
    WIN_LATE  = 2'd2,
    WIN_DONE  = 2'd3
  } win_e;

  // Which release window a count of serial-clock falls lands in.
  function automatic win_e classify(input int unsigned n,
                                    input int unsigned keep,
                                    input int unsigned stay,
                                    input int unsigned frame);
    if (n < keep)       return WIN_EARLY;
    else if (n < stay)  return WIN_MID;
    else if (n < frame) return WIN_LATE;
    else                return WIN_DONE;
  endfunction

  // Mode after select returns high.
  function automatic pm_mode_e after_rise(input pm_mode_e cur,
                                          input pm_mode_e src,
                                          input win_e w);
    case (cur)
      PM_NORMAL: return (w == WIN_MID) ? PM_PARTIAL : PM_NORMAL;
      PM_WAKING: begin
        case (w)
          WIN_EARLY: return src;
          WIN_MID:   return PM_FULL;
          default:   return PM_NORMAL;
        endcase
      end
      default:   return cur;
    endcase
  endfunction

  // A powered conversion is dropped when released before the frame ends.
  function automatic logic aborts(input pm_mode_e cur, input win_e w);
    return (cur == PM_NORMAL) && (w == WIN_MID || w == WIN_LATE);
  endfunction

  // {core, reference} enables.
  function automatic logic [1:0] power_flags(input pm_mode_e m);
    case (m)
      PM_PARTIAL: return 2'b01;
      PM_FULL:    return 2'b00;
      default:    return 2'b11;
    endcase
  endfunction

  function automatic logic track_state(input pm_mode_e m,
                                       input logic frame_open,
                                       input logic frame_end,
                                       input logic any_edge);
    case (m)
      PM_NORMAL: return !(frame_open && !frame_end);
      PM_WAKING: return any_edge;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pmc_edge_track.sv
module pmc_edge_track #(
  parameter int FRAME_EDGES = 16,
  parameter int CW          = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  output logic          cs_low,
  output logic          fall_evt,
  output logic          rise_evt,
  output logic          sclk_evt,
  output logic [CW-1:0] nfall
);

  localparam logic [CW-1:0] SAT = CW'(FRAME_EDGES);

  logic cs_q;
  logic sclk_q;

  assign fall_evt = cs_q & ~cs_n;
  assign rise_evt = ~cs_q & cs_n;
  assign sclk_evt = ~cs_q & ~cs_n & sclk_q & ~sclk;
  assign cs_low   = ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
      nfall  <= '0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
      if (fall_evt)
        nfall <= '0;
      else if (sclk_evt && nfall < SAT)
        nfall <= nfall + 1'b1;
    end
  end

endmodule

// File: rtl/pmc_wake_timer.sv
module pmc_wake_timer #(
  parameter int TW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt;

  assign expired = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (!expired)
      cnt <= cnt - 1'b1;
  end

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
#(
  parameter pm_mode_e RESET_MODE  = PM_NORMAL,
  parameter int       EDGE_KEEP   = 2,
  parameter int       EDGE_STAY   = 10,
  parameter int       FRAME_EDGES = 16,
  parameter int       CW          = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall_evt,
  input  logic          rise_evt,
  input  logic [CW-1:0] nfall,
  input  logic          ready,
  output pm_mode_e      mode_q,
  output logic          abort_q,
  output logic          frame_ok
);

  pm_mode_e src_q;
  win_e     win;

  assign win = classify(32'(nfall), EDGE_KEEP, EDGE_STAY, FRAME_EDGES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= RESET_MODE;
      src_q    <= RESET_MODE;
      abort_q  <= 1'b0;
      frame_ok <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      if (fall_evt) begin
        if (mode_q == PM_PARTIAL || mode_q == PM_FULL) begin
          src_q  <= mode_q;
          mode_q <= PM_WAKING;
        end
        frame_ok <= (mode_q == PM_NORMAL) && ready;
      end else if (rise_evt) begin
        frame_ok <= 1'b0;
        abort_q  <= aborts(mode_q, win);
        mode_q   <= after_rise(mode_q, src_q, win);
      end
    end
  end

endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
  import pmc_pkg::*;
#(
  parameter pm_mode_e RESET_MODE   = PM_NORMAL,
  parameter int       EDGE_KEEP    = 2,
  parameter int       EDGE_STAY    = 10,
  parameter int       FRAME_EDGES  = 16,
  parameter int       PUP_PART_CYC = 64,
  parameter int       PUP_FULL_CYC = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  output logic [1:0] mode,
  output logic       core_en,
  output logic       refbuf_en,
  output logic       abort_stb,
  output logic       track_en,
  output logic       ready,
  output logic       data_valid
);

  localparam int CW      = $clog2(FRAME_EDGES + 1);
  localparam int PUP_MAX = (PUP_FULL_CYC > PUP_PART_CYC) ? PUP_FULL_CYC : PUP_PART_CYC;
  localparam int TW      = $clog2(PUP_MAX + 1);
  localparam logic [CW-1:0] END_CNT = CW'(FRAME_EDGES);

  // Named internal events, also watched by the bound checker.
  logic          cs_low;
  logic          fall_evt;
  logic          rise_evt;
  logic          sclk_evt;
  logic [CW-1:0] nfall;
  logic          wake_done;
  logic          wake_load;
  logic [TW-1:0] wake_len;
  logic          frame_ok;
  pm_mode_e      mode_q;

  pmc_edge_track #(
    .FRAME_EDGES(FRAME_EDGES),
    .CW         (CW)
  ) u_edges (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .cs_low  (cs_low),
    .fall_evt(fall_evt),
    .rise_evt(rise_evt),
    .sclk_evt(sclk_evt),
    .nfall   (nfall)
  );

  assign wake_load = fall_evt && (mode_q == PM_PARTIAL || mode_q == PM_FULL);
  assign wake_len  = (mode_q == PM_FULL) ? TW'(PUP_FULL_CYC) : TW'(PUP_PART_CYC);

  pmc_wake_timer #(
    .TW(TW)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wake_load),
    .load_val(wake_len),
    .expired (wake_done)
  );

  pmc_mode_fsm #(
    .RESET_MODE (RESET_MODE),
    .EDGE_KEEP  (EDGE_KEEP),
    .EDGE_STAY  (EDGE_STAY),
    .FRAME_EDGES(FRAME_EDGES),
    .CW         (CW)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .fall_evt(fall_evt),
    .rise_evt(rise_evt),
    .nfall   (nfall),
    .ready   (ready),
    .mode_q  (mode_q),
    .abort_q (abort_stb),
    .frame_ok(frame_ok)
  );

  assign mode                 = mode_q;
  assign {core_en, refbuf_en} = power_flags(mode_q);
  assign ready                = (mode_q == PM_NORMAL) && wake_done;
  assign data_valid           = frame_ok && cs_low && (nfall >= END_CNT);
  assign track_en             = track_state(mode_q, cs_low, nfall >= END_CNT, nfall != '0);

endmodule

// File: rtl/adc_pwr_ctrl_chk.sv
module adc_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       core_en,
  input logic       refbuf_en,
  input logic       abort_stb,
  input logic       track_en,
  input logic       ready,
  input logic       data_valid,
  input logic       fall_evt,
  input logic       rise_evt
);

  p_deep_dark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (!core_en && !refbuf_en));

  p_light_ref_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> (!core_en && refbuf_en));

  p_ready_normal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mode == 2'd0));

  p_valid_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (mode == 2'd0 && ready));

  p_abort_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    abort_stb |=> !abort_stb);

  p_abort_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_stb |-> ($past(rise_evt) && $past(mode) == 2'd0));

  p_sleep_on_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'd1 || mode == 2'd2) && $past(mode) != mode) |-> $past(rise_evt));

  p_wake_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && $past(mode) != 2'd3) |-> $past(fall_evt));

  p_sleep_no_track_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 || mode == 2'd2) |-> !track_en);

endmodule

bind adc_pwr_ctrl adc_pwr_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .core_en   (core_en),
  .refbuf_en (refbuf_en),
  .abort_stb (abort_stb),
  .track_en  (track_en),
  .ready     (ready),
  .data_valid(data_valid),
  .fall_evt  (fall_evt),
  .rise_evt  (rise_evt)
);

// File: tb/sim_adc_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_adc_pwr_ctrl;

  localparam int PP = 40;
  localparam int PF = 300;
  localparam int FR = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b1;
  logic [1:0] mode;
  logic core_en, refbuf_en, abort_stb, track_en, ready, data_valid;

  adc_pwr_ctrl #(
    .PUP_PART_CYC(PP),
    .PUP_FULL_CYC(PF)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .mode(mode), .core_en(core_en), .refbuf_en(refbuf_en),
    .abort_stb(abort_stb), .track_en(track_en), .ready(ready),
    .data_valid(data_valid)
  );

  always #2 clk = ~clk;

  int ticks = 0;
  int n_chk = 0;
  int n_fail = 0;
  int m_mode = 0;
  int m_src = 0;
  int ready_at = 0;
  bit done = 0;

  task automatic tick();
    @(negedge clk);
    ticks++;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_ready();
    return (m_mode == 0 && ticks >= ready_at) ? 1 : 0;
  endfunction

  function automatic int exp_core(input int m);
    return (m == 0 || m == 3) ? 1 : 0;
  endfunction

  function automatic int exp_ref(input int m);
    return (m == 2) ? 0 : 1;
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // One select frame with n serial-clock falls, checked against the bench's model.
  task automatic frame(input int n);
    int pre, pre_rdy, t0, trk0, trk1, trk_end, dv_seen, mode_in, e_abort, e_dv;
    string rq;
    pre = m_mode;
    pre_rdy = exp_ready();
    t0 = ticks;
    trk1 = 1;
    trk_end = 1;
    cs_n = 1'b0;
    tick();
    mode_in = mode;
    trk0 = track_en;
    dv_seen = data_valid;
    if (pre == 1 || pre == 2) begin
      m_src = pre;
      m_mode = 3;
      ready_at = t0 + ((pre == 2) ? PF : PP) + 1;
    end
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0;
      tick();
      if (i == 0) trk1 = track_en;
      if (i == FR - 1) trk_end = track_en;
      if (data_valid) dv_seen = 1;
      tick();
      sclk = 1'b1;
      tick();
      tick();
    end
    cs_n = 1'b1;
    tick();
    e_abort = (m_mode == 0 && n >= 2 && n < FR) ? 1 : 0;
    e_dv = (pre == 0 && pre_rdy == 1 && n >= FR) ? 1 : 0;
    if (m_mode == 0) begin
      if (n < 2) rq = "R2";
      else if (n < 10) rq = "R3";
      else if (n < FR) rq = "R4";
      else rq = "R5";
      if (n >= 2 && n < 10) m_mode = 1;
      check("R12", "track after select fall", trk0, 0);
      if (n >= FR) check("R12", "track after last conversion edge", trk_end, 1);
    end else begin
      if (n < 2) rq = "R7";
      else if (n < 10) rq = "R8";
      else rq = "R9";
      check("R6", "mode while waking", mode_in, 3);
      check("R6", "track before first edge", trk0, 0);
      if (n >= 1) check("R6", "track after first edge", trk1, 1);
      if (n < 2) m_mode = m_src;
      else if (n < 10) m_mode = 2;
      else m_mode = 0;
    end
    check(rq, "mode after release", mode, m_mode);
    check(rq, "abort strobe", abort_stb, e_abort);
    check((e_dv == 1) ? "R5" : "R11", "data valid seen", dv_seen, e_dv);
    check("R9", "ready", ready, exp_ready());
    check("R10", "core enable", core_en, exp_core(m_mode));
    check("R10", "reference enable", refbuf_en, exp_ref(m_mode));
    if (m_mode == 1 || m_mode == 2) check("R12", "track in sleep", track_en, 0);
    tick();
    check(rq, "abort strobe cleared", abort_stb, 0);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    for (int i = 0; i < 5; i++) tick();
    // R1 reset state
    check("R1", "mode", mode, 0);
    check("R1", "ready", ready, 1);
    check("R1", "abort", abort_stb, 0);
    check("R1", "data valid", data_valid, 0);
    check("R1", "core enable", core_en, 1);
    check("R1", "reference enable", refbuf_en, 1);
    check("R1", "track", track_en, 1);
    rst_n = 1'b1;
    tick();

    frame(1);    // R2 glitch
    frame(0);    // R2 empty frame
    frame(FR);   // R5 full valid frame
    frame(12);   // R4 late drop
    frame(5);    // R3 into light sleep
    frame(0);    // R7 back to light sleep
    frame(3);    // R8 light wake released mid -> deep
    frame(1);    // R7 back to deep
    frame(12);   // R9 deep wake -> normal, not ready
    frame(FR);   // R11 frame while not ready
    if (m_mode == 0 && ticks < ready_at - 1) begin
      while (ticks < ready_at - 1) tick();
      check("R9", "ready one cycle early", ready, 0);
      tick();
      check("R9", "ready on expiry", ready, 1);
    end
    frame(FR);   // R5 valid again
    frame(9);    // R3 boundary: 9 falls -> light sleep
    frame(10);   // R9 light wake
    for (int i = 0; i < PP; i++) tick();
    frame(10);   // R4 boundary: 10 falls stays normal
    frame(2);    // R3 boundary: 2 falls -> light sleep
    frame(FR + 3); // R9 long wake frame
    for (int i = 0; i < PP; i++) tick();
    frame(15);   // R4 upper boundary

    for (int k = 0; k < 120; k++) begin
      int n, idle;
      n = $urandom_range(0, 20);
      frame(n);
      idle = ($urandom_range(0, 9) == 0) ? PF + 20 : $urandom_range(0, 8);
      for (int j = 0; j < idle; j++) tick();
    end

    done = 1;
    report();
    $finish;
  end

endmodule